// File: doc/BRIEF.md
# Timeslot Subchannel Bit Packer

This block carries a sub-rate channel of 8 to 64 kbit/s inside an 8-bit timeslot that repeats every 125 µs frame. On each frame strobe it takes a configured run of consecutive bits from the incoming timeslot byte. It collects those bits into whole bytes and hands each byte to a receive FIFO. In the other direction it draws bits from bytes popped off a transmit FIFO and places them at the same positions of the outgoing timeslot byte. Partial bytes carry over from one frame to the next in both directions, so a 2-bit or 3-bit channel still moves through the FIFOs as full bytes.

An 8-bit configuration word selects the channel:
- bits [2:0] give the count of bits per frame. Code 0 means 8 bits, and codes 1 to 7 mean that many bits.
- bits [5:3] give the lowest timeslot bit position used.
- bit 6 freezes the transmit output on the previous frame. This works only while the transparent input is high.
- bit 7 inverts the data in both directions.

The value 0x02 gives a 16 kbit/s channel in bits 0 and 1. A separate enable input turns the channel off. While it is off, no FIFO is touched.

A two-state controller governs the channel. ST_OFF is entered at reset and on any strobe that sees the enable low. ST_RUN is entered on a strobe that sees the enable high. The OFF-to-RUN transition, and any strobe in ST_RUN that presents a configuration word different from the active one, clear both partial-bit stores before the frame is processed. The RUN-to-OFF transition blanks the outgoing slot.

Top module: `subch_packer`

## Requirements
- R1: After reset, tx_slot is 0xFF, rx_push, tx_pop and underrun are 0, and the active configuration is 0x00.
- R2: Count field code 0 processes 8 bits per frame; code k (1..7) processes k bits.
- R3: Bits are taken from positions start, start+1, ..., where start is the value of bits [5:3]. If start plus the count exceeds 8, only the bits up to position 7 are processed.
- R4: Received bits enter an accumulator least significant bit first. When 8 bits have gathered, one byte is pushed with rx_push high for one cycle, in the cycle after the strobe. Any extra bits carry into the next byte.
- R5: Transmit bits leave a holding store least significant bit first. When the store holds fewer bits than the frame needs, tx_pop is high during the strobe cycle and tx_pop_data is taken in that cycle. There is at most one pop per frame.
- R6: tx_slot bits outside the selected field are 1.
- R7: With bit 7 set, extracted receive bits and inserted transmit data bits are inverted.
- R8: With bit 6 set and transparent high, a strobe leaves tx_slot unchanged and causes no pop, while receive continues. With transparent low, bit 6 has no effect.
- R9: A strobe with chan_en low causes no push and no pop, sets tx_slot to 0xFF, and makes the next enabled strobe start from empty stores.
- R10: A configuration change takes effect at the next enabled strobe and discards partial bits in both directions.
- R11: If a pop is needed while tx_empty is high, the missing bits are sent as 1 (not inverted), the holding store is emptied, and underrun goes high and stays high until reset.
- R12: tx_slot, rx_push and rx_push_data change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable, sampled at strobes |
| transparent | input | 1 | Transparent mode; allows the freeze bit to act |
| cfg_word | input | 8 | Configuration word (count, start, freeze, invert) |
| frame_stb | input | 1 | One-cycle frame strobe |
| rx_slot | input | 8 | Incoming timeslot byte, valid with frame_stb |
| tx_slot | output | 8 | Outgoing timeslot byte |
| rx_push | output | 1 | Receive FIFO write strobe |
| rx_push_data | output | 8 | Receive FIFO write data |
| tx_pop | output | 1 | Transmit FIFO read strobe |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop_data | input | 8 | Transmit FIFO head byte (show-ahead) |
| underrun | output | 1 | Sticky transmit underrun flag |

## Verification
The bench targets bit runs that straddle byte boundaries, such as 3 bits from position 2, where a wrong carry would push bytes with shifted or repeated bits. It also runs fields clamped at bit 7, where a design without the clamp would wrap into low positions or overrun its store. Mid-stream configuration changes and disable/enable cycles check that stale partial bits are dropped. A design that kept them would emit a mixed byte. Freeze with and without transparent mode, and an empty transmit FIFO, catch designs that pop when they should not, invert the fill bits, or let the underrun flag clear.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } sbp_state_e;
endpackage

// File: rtl/sbp_rx_pack.sv
module sbp_rx_pack #(
    parameter int SLOT_W = 8,
    parameter int FW     = $clog2(SLOT_W),
    parameter int CW     = FW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clr,
    input  logic              inv,
    input  logic [FW-1:0]     start,
    input  logic [CW-1:0]     eff,
    input  logic [SLOT_W-1:0] slot,
    output logic              push,
    output logic [SLOT_W-1:0] push_data
);
    logic [SLOT_W-1:0]   acc_q, base_acc, mask, field;
    logic [CW-1:0]       cnt_q, base_cnt;
    logic [2*SLOT_W-1:0] merged;
    logic [CW:0]         total;

    always_comb begin
        base_acc = clr ? '0 : acc_q;
        base_cnt = clr ? '0 : cnt_q;
        for (int i = 0; i < SLOT_W; i++) begin
            mask[i] = (i < int'(eff));
        end
        field  = ((slot >> start) & mask) ^ ({SLOT_W{inv}} & mask);
        merged = {{SLOT_W{1'b0}}, base_acc} | ({{SLOT_W{1'b0}}, field} << base_cnt);
        total  = {1'b0, base_cnt} + {1'b0, eff};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            push      <= 1'b0;
            push_data <= '0;
        end else begin
            push <= 1'b0;
            if (step) begin
                if (total >= (CW+1)'(SLOT_W)) begin
                    push      <= 1'b1;
                    push_data <= merged[SLOT_W-1:0];
                    acc_q     <= merged[2*SLOT_W-1:SLOT_W];
                    cnt_q     <= CW'(total - (CW+1)'(SLOT_W));
                end else begin
                    acc_q <= merged[SLOT_W-1:0];
                    cnt_q <= total[CW-1:0];
                end
            end
        end
    end

    // R4: a byte leaves only after a processed frame
    a_r4_push_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(step));
    // R4: leftover bits never reach a full byte
    a_r4_carry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(SLOT_W));
endmodule

// File: rtl/sbp_tx_unpack.sv
module sbp_tx_unpack #(
    parameter int SLOT_W = 8,
    parameter int FW     = $clog2(SLOT_W),
    parameter int CW     = FW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clr,
    input  logic              blank,
    input  logic              freeze,
    input  logic              inv,
    input  logic [FW-1:0]     start,
    input  logic [CW-1:0]     eff,
    input  logic              fifo_empty,
    input  logic [SLOT_W-1:0] fifo_data,
    output logic              pop,
    output logic [SLOT_W-1:0] slot_q,
    output logic              underrun_q
);
    logic [SLOT_W-1:0]   hold_q, base_hold, mask, fmask, dbit, slot_nxt;
    logic [CW-1:0]       cnt_q, base_cnt;
    logic [2*SLOT_W-1:0] pool, rest;
    logic [CW:0]         pool_cnt;
    logic                need, starve;

    always_comb begin
        base_hold = clr ? '0 : hold_q;
        base_cnt  = clr ? '0 : cnt_q;
        need      = step && !freeze && (base_cnt < eff);
        pop       = need && !fifo_empty;
        starve    = need && fifo_empty;
        pool      = {{SLOT_W{1'b0}}, base_hold};
        pool_cnt  = {1'b0, base_cnt};
        if (pop) begin
            pool     = pool | ({{SLOT_W{1'b0}}, fifo_data} << base_cnt);
            pool_cnt = pool_cnt + (CW+1)'(SLOT_W);
        end
        for (int i = 0; i < SLOT_W; i++) begin
            mask[i] = (i < int'(eff));
            dbit[i] = (i < int'(pool_cnt)) ? (pool[i] ^ inv) : 1'b1;
        end
        fmask    = mask << start;
        slot_nxt = (fmask & (dbit << start)) | ~fmask;
        rest     = pool >> eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            cnt_q      <= '0;
            slot_q     <= '1;
            underrun_q <= 1'b0;
        end else if (blank) begin
            slot_q <= '1;
        end else if (step && freeze) begin
            hold_q <= base_hold;
            cnt_q  <= base_cnt;
        end else if (step) begin
            slot_q <= slot_nxt;
            if (starve) begin
                hold_q     <= '0;
                cnt_q      <= '0;
                underrun_q <= 1'b1;
            end else begin
                hold_q <= rest[SLOT_W-1:0];
                cnt_q  <= CW'(pool_cnt - {1'b0, eff});
            end
        end
    end

    // R11: the underrun flag never falls without reset
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_q |=> underrun_q);
    // R5: the holding store never exceeds one byte
    a_r5_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SLOT_W));
endmodule

// File: rtl/subch_packer.sv
module subch_packer #(
    parameter int SLOT_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             chan_en,
    input  logic                             transparent,
    input  logic [2*$clog2(SLOT_W)+1:0]      cfg_word,
    input  logic                             frame_stb,
    input  logic [SLOT_W-1:0]                rx_slot,
    output logic [SLOT_W-1:0]                tx_slot,
    output logic                             rx_push,
    output logic [SLOT_W-1:0]                rx_push_data,
    output logic                             tx_pop,
    input  logic                             tx_empty,
    input  logic [SLOT_W-1:0]                tx_pop_data,
    output logic                             underrun
);
    import sbp_pkg::*;

    localparam int FW    = $clog2(SLOT_W);
    localparam int CW    = FW + 1;
    localparam int CFG_W = 2 * FW + 2;

    sbp_state_e       state_q, state_d;
    logic [CFG_W-1:0] act_q;
    logic [FW-1:0]    cnt_code, start;
    logic [CW-1:0]    nbits, room, eff;
    logic             freeze_bit, inv_bit, run, blank, clr;

    assign cnt_code   = cfg_word[FW-1:0];
    assign start      = cfg_word[2*FW-1:FW];
    assign freeze_bit = cfg_word[2*FW];
    assign inv_bit    = cfg_word[2*FW+1];

    always_comb begin
        nbits = (cnt_code == '0) ? CW'(SLOT_W) : {1'b0, cnt_code};
        room  = CW'(SLOT_W) - {1'b0, start};
        eff   = (nbits < room) ? nbits : room;
    end

    always_comb begin
        run   = frame_stb && chan_en;
        blank = frame_stb && !chan_en;
        clr   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run) begin
                    clr     = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (blank) begin
                    state_d = ST_OFF;
                end else if (run && (cfg_word != act_q)) begin
                    clr = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            if (run) begin
                act_q <= cfg_word;
            end
        end
    end

    sbp_rx_pack #(.SLOT_W(SLOT_W), .FW(FW), .CW(CW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (run),
        .clr       (clr),
        .inv       (inv_bit),
        .start     (start),
        .eff       (eff),
        .slot      (rx_slot),
        .push      (rx_push),
        .push_data (rx_push_data)
    );

    sbp_tx_unpack #(.SLOT_W(SLOT_W), .FW(FW), .CW(CW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (run),
        .clr        (clr),
        .blank      (blank),
        .freeze     (freeze_bit && transparent),
        .inv        (inv_bit),
        .start      (start),
        .eff        (eff),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_pop_data),
        .pop        (tx_pop),
        .slot_q     (tx_slot),
        .underrun_q (underrun)
    );

    // R5: never read an empty FIFO
    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    // R9: a disabled strobe touches no FIFO and blanks the slot
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !chan_en) |-> !tx_pop);
    a_r9_off_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !chan_en) |=> (tx_slot == '1) && !rx_push);
    // R8: freeze in transparent mode holds the slot and skips the pop
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (run && freeze_bit && transparent) |=> $stable(tx_slot));
    // R12: outputs move only after a strobe
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(tx_slot) && !rx_push));
endmodule

// File: tb/sim_subch_packer.sv
module sim_subch_packer;
    logic       clk = 1'b0;
    logic       rst_n, chan_en, transparent, frame_stb, tx_empty;
    logic [7:0] cfg_word, rx_slot, tx_pop_data;
    logic [7:0] tx_slot, rx_push_data;
    logic       rx_push, tx_pop, underrun;

    always #2 clk = ~clk;

    subch_packer u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .transparent(transparent),
        .cfg_word(cfg_word), .frame_stb(frame_stb), .rx_slot(rx_slot),
        .tx_slot(tx_slot), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_pop(tx_pop), .tx_empty(tx_empty), .tx_pop_data(tx_pop_data),
        .underrun(underrun)
    );

    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;
    string      tag = "R1";
    bit         rxq[$];
    bit         txq[$];
    logic [7:0] fifo[$];
    logic [7:0] act = 8'h00;
    bit         m_off = 1;
    logic [7:0] exp_tx = 8'hFF;
    logic [7:0] exp_pdata = 8'h00;
    bit         exp_push = 0;
    bit         exp_und = 0;
    logic [7:0] lf = 8'h5A;

    task automatic chk(string t, string what, logic [31:0] a, logic [31:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, a, e);
        end
    endtask

    task automatic cycle(bit stb, logic [7:0] slot);
        bit         ep;
        int         n, st, e;
        bit         lp, iv;
        logic [7:0] b, s;
        @(negedge clk);
        chk(tag, "rx_push", 32'(rx_push), 32'(exp_push));
        if (exp_push) chk(tag, "rx_push_data", 32'(rx_push_data), 32'(exp_pdata));
        chk(tag, "tx_slot", 32'(tx_slot), 32'(exp_tx));
        chk(tag, "underrun", 32'(underrun), 32'(exp_und));
        frame_stb   = stb;
        rx_slot     = slot;
        tx_empty    = (fifo.size() == 0);
        tx_pop_data = (fifo.size() == 0) ? 8'h00 : fifo[0];
        #1;
        ep = 0;
        exp_push = 0;
        if (stb && !chan_en) begin
            exp_tx = 8'hFF;
            m_off  = 1;
        end else if (stb) begin
            if (m_off || cfg_word != act) begin
                rxq.delete();
                txq.delete();
            end
            act   = cfg_word;
            m_off = 0;
            n  = (cfg_word[2:0] == 0) ? 8 : int'(cfg_word[2:0]);
            st = int'(cfg_word[5:3]);
            e  = (n > 8 - st) ? 8 - st : n;
            lp = cfg_word[6];
            iv = cfg_word[7];
            for (int i = 0; i < e; i++) rxq.push_back(slot[st+i] ^ iv);
            if (rxq.size() >= 8) begin
                exp_push = 1;
                for (int i = 0; i < 8; i++) exp_pdata[i] = rxq.pop_front();
            end
            if (!(lp && transparent)) begin
                if (txq.size() < e && fifo.size() > 0) begin
                    b  = fifo.pop_front();
                    ep = 1;
                    for (int i = 0; i < 8; i++) txq.push_back(b[i]);
                end
                s = 8'hFF;
                for (int i = 0; i < e; i++) begin
                    if (txq.size() > 0) s[st+i] = txq.pop_front() ^ iv;
                    else begin
                        s[st+i] = 1'b1;
                        exp_und = 1;
                    end
                end
                exp_tx = s;
            end
        end
        chk(tag, "tx_pop", 32'(tx_pop), 32'(ep));
    endtask

    task automatic frames(string t, logic [7:0] cfg, int cnt);
        tag      = t;
        cfg_word = cfg;
        for (int k = 0; k < cnt; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cycle(1, lf);
            cycle(0, 8'h00);
            cycle(0, 8'h00);
        end
    endtask

    task automatic feed(int cnt);
        for (int k = 0; k < cnt; k++) fifo.push_back(8'(8'h3C + 8'(k * 37)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; chan_en = 0; transparent = 0; cfg_word = 8'h00;
        frame_stb = 0; rx_slot = 8'h00; tx_empty = 1; tx_pop_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tag = "R1";
        for (int k = 0; k < 3; k++) cycle(0, 8'h00);
        chan_en = 1;
        feed(6);
        frames("R2", 8'h00, 5);           // 8 bits per frame
        feed(6);
        frames("R2", 8'h07, 7);           // 7 bits per frame
        feed(6);
        frames("R4", 8'h02, 12);          // 2 bits from bit 0
        feed(6);
        frames("R3", 8'h13, 12);          // 3 bits from bit 2
        feed(4);
        frames("R3", 8'h35, 10);          // 5 requested from bit 6, clamped to 2
        feed(6);
        frames("R5", 8'h0B, 12);          // 3 bits from bit 1
        frames("R6", 8'h21, 9);           // 1 bit from bit 4
        feed(6);
        frames("R7", 8'h94, 10);          // inverted, 4 bits from bit 2
        feed(4);
        transparent = 1;
        frames("R8", 8'h44, 6);           // frozen transmit
        transparent = 0;
        frames("R8", 8'h44, 6);           // freeze ignored
        feed(4);
        frames("R10", 8'h03, 2);
        frames("R10", 8'h05, 6);          // change drops partial bits
        frames("R12", 8'h05, 2);
        chan_en = 0;
        frames("R9", 8'h05, 3);
        for (int k = 0; k < 4; k++) cycle(0, 8'h00);
        chan_en = 1;
        feed(4);
        frames("R9", 8'h05, 5);
        fifo.delete();
        frames("R11", 8'h83, 6);          // empty FIFO, inverted data
        frames("R11", 8'h06, 3);
        for (int k = 0; k < 3; k++) cycle(0, 8'h00);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule